// File: doc/BRIEF.md
# Pseudo-Static RAM Power-Up and Standby Sequencer

This block sits on the host side of a refresh-internal pseudo-static RAM and owns the memory's control pins whenever the memory is not ready for normal traffic. After reset it keeps chip select and the mode pin high for a programmable number of clock cycles. It then issues a fixed number of dummy reads. Each dummy read pulses chip select low while output enable and write enable stay high, so the shared data bus is never driven from either side. After the last dummy read it raises `ready` and connects the access controller's control pins straight through to the memory.

Once the memory is ready, the access controller can park it in one of two standby states. Light standby keeps chip select high with mode high, and the array contents are kept. Deep standby keeps chip select high and drives mode low, and the contents are lost. A wake request from light standby returns to ready at once. A wake request from deep standby reruns the whole power-up sequence. While the sequencer owns the bus, a pending access request is answered with a stall, and the access controller's pin values have no effect on the memory.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `rstN` is low, `memCsN`, `memOeN`, `memWeN` and `memMode` are 1 and `ready` is 0.
- R2: After reset release, `memCsN` and `memMode` stay high, and `memCsN` first goes low on the WAIT_CYC-th rising clock edge after release.
- R3: Between reset release and `ready`, exactly NUM_READS low pulses appear on `memCsN`, each LOW_CYC cycles long. Each pulse is followed by HIGH_CYC cycles of `memCsN` high. `memOeN`, `memWeN` and `memMode` stay 1 throughout.
- R4: `ready` rises on edge WAIT_CYC + NUM_READS*(LOW_CYC+HIGH_CYC) after release. While `ready` is 1, the memory pins equal the access pins {csN, oeN, weN, lbN, ubN} in the same cycle, and `memMode` is 1.
- R5: While `ready` is 0, `accStall` equals `accReq` and the access pins have no effect on the memory pins. While `ready` is 1, `accStall` is 0.
- R6: `reqStby1` sampled high in the ready state enters light standby on that edge: `ready` 0, `memCsN` 1, `memMode` 1, `memOeN` 1. `reqWake` in light standby restores `ready` on the next edge, with no new initialization.
- R7: `reqStby2`, sampled in the ready state or in light standby, enters deep standby: `memMode` 0 with `memCsN` already 1 in that same cycle. When `reqStby1` and `reqStby2` are both high in the ready state, deep standby wins.
- R8: `reqWake` in deep standby sets `memMode` to 1 on the accepting edge and reruns the full initialization, with the timing of R2 to R4 counted from that edge.
- R9: Standby requests during initialization and `reqWake` in the ready state have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStby1 | input | 1 | Request light standby (data kept) |
| reqStby2 | input | 1 | Request deep standby (data lost) |
| reqWake | input | 1 | Request leaving standby |
| accReq | input | 1 | Access controller wants the bus |
| accCsN | input | 1 | Access controller chip select, active low |
| accOeN | input | 1 | Access controller output enable, active low |
| accWeN | input | 1 | Access controller write enable, active low |
| accLbN | input | 1 | Access controller low byte select, active low |
| accUbN | input | 1 | Access controller high byte select, active low |
| memCsN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memLbN | output | 1 | Memory low byte select, active low |
| memUbN | output | 1 | Memory high byte select, active low |
| memMode | output | 1 | Memory mode pin; 0 selects deep standby |
| ready | output | 1 | Memory initialized and owned by access controller |
| accStall | output | 1 | Access request held off |

## Verification
The power-up sequence is traced three ways. The first trace follows reset with the access pins held low and a request pending, which shows that the access pins cannot leak through during initialization. The second follows a wake from deep standby reached through light standby, with standby requests injected during the wait and during a dummy read; this separates a sequencer that ignores such requests from one that aborts or restarts on them. The third follows a wake from deep standby entered with both standby requests high at once, which shows the priority order. A table of access-pin patterns applied in the ready state separates a true pass-through from one that swaps or forces any pin. The standby checks show apart a light standby that keeps its fast wake from one that needlessly reruns initialization.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [2:0] {
    S_WAIT  = 3'd0,
    S_RDLO  = 3'd1,
    S_RDHI  = 3'd2,
    S_READY = 3'd3,
    S_STBY1 = 3'd4,
    S_STBY2 = 3'd5
  } seqState_t;

  typedef struct packed {
    logic csN;
    logic oeN;
    logic weN;
    logic lbN;
    logic ubN;
  } busPins_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldWait;
    logic ldLow;
    logic ldHigh;
    logic decCnt;
    logic incRead;
    logic clrRead;
    logic ownBus;   // access controller drives the pins
    logic csHigh;   // chip select level when sequencer owns the pins
    logic modeLow;  // deep standby
  } seqStrobe_t;

endpackage

// File: rtl/psram_seq_dp.sv
module psram_seq_dp
  import psram_seq_pkg::*;
#(
  parameter int WAIT_CYC  = 50000,
  parameter int LOW_CYC   = 20,
  parameter int HIGH_CYC  = 3,
  parameter int NUM_READS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  input  busPins_t   accPins,
  input  logic       accReq,
  output logic       cntZero,
  output logic       lastRead,
  output busPins_t   memPins,
  output logic       memMode,
  output logic       accStall
);

  localparam int MAX_AB = (WAIT_CYC > LOW_CYC) ? WAIT_CYC : LOW_CYC;
  localparam int MAX_C  = (MAX_AB > HIGH_CYC) ? MAX_AB : HIGH_CYC;
  localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C + 1);
  localparam int RW     = (NUM_READS < 2) ? 1 : $clog2(NUM_READS + 1);

  logic [CW-1:0] cnt;
  logic [RW-1:0] rdCnt;

  // one shared down counter for the wait and both read phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= CW'(WAIT_CYC - 1);
      rdCnt <= '0;
    end else begin
      if (stb.ldWait)
        cnt <= CW'(WAIT_CYC - 1);
      else if (stb.ldLow)
        cnt <= CW'(LOW_CYC - 1);
      else if (stb.ldHigh)
        cnt <= CW'(HIGH_CYC - 1);
      else if (stb.decCnt && cnt != '0)
        cnt <= cnt - 1'b1;

      if (stb.clrRead)
        rdCnt <= '0;
      else if (stb.incRead)
        rdCnt <= rdCnt + 1'b1;
    end
  end

  assign cntZero  = (cnt == '0);
  assign lastRead = (rdCnt == RW'(NUM_READS - 1));

  // pin mux: pass through when owned by the access side
  always_comb begin
    if (stb.ownBus) begin
      memPins = accPins;
    end else begin
      memPins.csN = stb.csHigh;
      memPins.oeN = 1'b1;
      memPins.weN = 1'b1;
      memPins.lbN = stb.csHigh;
      memPins.ubN = stb.csHigh;
    end
    memMode  = ~stb.modeLow;
    accStall = accReq & ~stb.ownBus;
  end

  // R3: the dummy read index never passes the last read
  a_r3_read_bound: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt < RW'(NUM_READS));

  // R3: a dummy read index only moves at the end of a high phase
  a_r3_read_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdCnt != $past(rdCnt) && rdCnt != '0) |-> $past(memPins.csN));

endmodule

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
  import psram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStby1,
  input  logic       reqStby2,
  input  logic       reqWake,
  input  logic       cntZero,
  input  logic       lastRead,
  output seqStrobe_t stb,
  output logic       ready
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_WAIT;
    else       state <= nxt;
  end

  always_comb begin
    nxt        = state;
    stb        = '0;
    stb.csHigh = 1'b1;
    unique case (state)
      S_WAIT: begin
        stb.decCnt = 1'b1;
        if (cntZero) begin
          nxt       = S_RDLO;
          stb.ldLow = 1'b1;
        end
      end
      S_RDLO: begin
        stb.csHigh = 1'b0;
        stb.decCnt = 1'b1;
        if (cntZero) begin
          nxt        = S_RDHI;
          stb.ldHigh = 1'b1;
        end
      end
      S_RDHI: begin
        stb.decCnt = 1'b1;
        if (cntZero) begin
          if (lastRead) begin
            nxt         = S_READY;
            stb.clrRead = 1'b1;
          end else begin
            nxt         = S_RDLO;
            stb.ldLow   = 1'b1;
            stb.incRead = 1'b1;
          end
        end
      end
      S_READY: begin
        stb.ownBus = 1'b1;
        if (reqStby2)      nxt = S_STBY2;
        else if (reqStby1) nxt = S_STBY1;
      end
      S_STBY1: begin
        if (reqStby2)     nxt = S_STBY2;
        else if (reqWake) nxt = S_READY;
      end
      S_STBY2: begin
        stb.modeLow = 1'b1;
        if (reqWake) begin
          nxt        = S_WAIT;
          stb.ldWait = 1'b1;
        end
      end
      default: begin
        nxt        = S_WAIT;
        stb.ldWait = 1'b1;
      end
    endcase
  end

  assign ready = (state == S_READY);

  // R4 / R6: ready only comes from the last dummy read or a light-standby wake
  a_r4_ready_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(state) == S_RDHI || $past(state) == S_STBY1));

  // R8: waking from deep standby restarts the wait
  a_r8_wake_reinit: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STBY2 && reqWake) |=> (state == S_WAIT));

  // R9: no standby entry while initializing
  a_r9_init_no_stby: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {S_WAIT, S_RDLO, S_RDHI}) |=> !(state inside {S_STBY1, S_STBY2}));

  // R7: deep standby wins when both requests arrive together
  a_r7_stby2_wins: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_READY && reqStby2) |=> (state == S_STBY2));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_seq_pkg::*;
#(
  parameter int WAIT_CYC  = 50000,
  parameter int LOW_CYC   = 20,
  parameter int HIGH_CYC  = 3,
  parameter int NUM_READS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqStby1,
  input  logic reqStby2,
  input  logic reqWake,
  input  logic accReq,
  input  logic accCsN,
  input  logic accOeN,
  input  logic accWeN,
  input  logic accLbN,
  input  logic accUbN,
  output logic memCsN,
  output logic memOeN,
  output logic memWeN,
  output logic memLbN,
  output logic memUbN,
  output logic memMode,
  output logic ready,
  output logic accStall
);

  seqStrobe_t stb;
  busPins_t   accPins;
  busPins_t   memPins;
  logic       cntZero;
  logic       lastRead;

  assign accPins = '{csN: accCsN, oeN: accOeN, weN: accWeN, lbN: accLbN, ubN: accUbN};

  psram_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqStby1 (reqStby1),
    .reqStby2 (reqStby2),
    .reqWake  (reqWake),
    .cntZero  (cntZero),
    .lastRead (lastRead),
    .stb      (stb),
    .ready    (ready)
  );

  psram_seq_dp #(
    .WAIT_CYC  (WAIT_CYC),
    .LOW_CYC   (LOW_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .NUM_READS (NUM_READS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .accPins  (accPins),
    .accReq   (accReq),
    .cntZero  (cntZero),
    .lastRead (lastRead),
    .memPins  (memPins),
    .memMode  (memMode),
    .accStall (accStall)
  );

  assign memCsN = memPins.csN;
  assign memOeN = memPins.oeN;
  assign memWeN = memPins.weN;
  assign memLbN = memPins.lbN;
  assign memUbN = memPins.ubN;

  // R7: chip select is high no later than mode falls
  a_r7_cs_before_mode: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memMode) |-> memCsN);

  // R3: output and write enables stay off while not ready
  a_r3_bus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (memOeN && memWeN));

  // R2 / R3: a dummy read never starts with mode low
  a_r2_mode_during_read: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCsN) && !ready) |-> memMode);

  // R5: pending requests are held off until ready
  a_r5_stall: assert property (@(posedge clk) disable iff (!rstN)
    (accReq && !ready) |-> accStall);

endmodule

// File: tb/psram_pwr_seq_bench.sv
`timescale 1ns/1ps
module psram_pwr_seq_bench;

  localparam int WAIT_CYC  = 40;
  localparam int LOW_CYC   = 4;
  localparam int HIGH_CYC  = 2;
  localparam int NUM_READS = 3;
  localparam int READY_AT  = WAIT_CYC + NUM_READS * (LOW_CYC + HIGH_CYC);
  localparam int TRACE_LEN = READY_AT + 12;

  // {accReq, csN, oeN, weN, lbN, ubN} -> {accStall, memCsN, memOeN, memWeN, memLbN, memUbN}
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {6'b1_11111, 6'b0_11111},
    {6'b1_00111, 6'b0_00111},
    {6'b1_01000, 6'b0_01000},
    {6'b0_01110, 6'b0_01110},
    {6'b1_01101, 6'b0_01101},
    {6'b0_10101, 6'b0_10101},
    {6'b1_01010, 6'b0_01010},
    {6'b0_00000, 6'b0_00000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStby1 = 1'b0, reqStby2 = 1'b0, reqWake = 1'b0, accReq = 1'b0;
  logic accCsN = 1'b1, accOeN = 1'b1, accWeN = 1'b1, accLbN = 1'b1, accUbN = 1'b1;
  logic memCsN, memOeN, memWeN, memLbN, memUbN, memMode, ready, accStall;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  psram_pwr_seq #(
    .WAIT_CYC(WAIT_CYC), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .NUM_READS(NUM_READS)
  ) u_psram_pwr_seq (
    .clk(clk), .rstN(rstN), .reqStby1(reqStby1), .reqStby2(reqStby2), .reqWake(reqWake),
    .accReq(accReq), .accCsN(accCsN), .accOeN(accOeN), .accWeN(accWeN), .accLbN(accLbN),
    .accUbN(accUbN), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memLbN(memLbN),
    .memUbN(memUbN), .memMode(memMode), .ready(ready), .accStall(accStall)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setAcc(input logic [4:0] p);
    {accCsN, accOeN, accWeN, accLbN, accUbN} = p;
  endtask

  // called at the negedge just after the edge that starts initialization
  task automatic runInit(input string tag, input bit inject);
    int firstLow = 0, readyAt = 0, pulses = 0, badLow = 0, badHigh = 0;
    int modeBad = 0, oeBad = 0, stallBad = 0, runLen = 0;
    logic prevCs = 1'b1;
    for (int k = 1; k <= TRACE_LEN; k++) begin
      @(negedge clk);
      if (readyAt == 0) begin
        if (ready) readyAt = k;
        else begin
          if (!memMode) modeBad++;
          if (!memOeN || !memWeN) oeBad++;
          if (accStall != accReq) stallBad++;
          if (memCsN != prevCs) begin
            if (!memCsN) begin
              pulses++;
              if (firstLow == 0) firstLow = k;
              else if (runLen != HIGH_CYC) badHigh++;
            end else if (runLen != LOW_CYC) badLow++;
            runLen = 1;
          end else runLen++;
          prevCs = memCsN;
        end
      end
      reqStby1 = inject && (k == 10 || k == 45);
      reqStby2 = inject && (k == 10 || k == 45);
    end
    reqStby1 = 1'b0;
    reqStby2 = 1'b0;
    if (prevCs && runLen != HIGH_CYC) badHigh++;
    chk(firstLow == WAIT_CYC, {"R2 first cs fall ", tag}, firstLow, WAIT_CYC);
    chk(pulses == NUM_READS, {"R3 dummy read count ", tag}, pulses, NUM_READS);
    chk(badLow == 0, {"R3 cs low width ", tag}, badLow, 0);
    chk(badHigh == 0, {"R3 cs high gap ", tag}, badHigh, 0);
    chk(modeBad == 0, {"R3 mode high in init ", tag}, modeBad, 0);
    chk(oeBad == 0, {"R3 oe/we high in init ", tag}, oeBad, 0);
    chk(stallBad == 0, {"R5 stall in init ", tag}, stallBad, 0);
    chk(readyAt == READY_AT, {"R4 ready edge ", tag}, readyAt, READY_AT);
    if (inject) chk(readyAt == READY_AT, {"R9 requests ignored in init ", tag}, readyAt, READY_AT);
  endtask

  task automatic pulseReq(input int which);
    @(negedge clk);
    if (which == 1) reqStby1 = 1'b1;
    if (which == 2) reqStby2 = 1'b1;
    if (which == 3) begin reqStby1 = 1'b1; reqStby2 = 1'b1; end
    if (which == 4) reqWake = 1'b1;
    @(negedge clk);
    reqStby1 = 1'b0; reqStby2 = 1'b0; reqWake = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with access pins driven active
    setAcc(5'b00000);
    accReq = 1'b1;
    repeat (3) @(negedge clk);
    chk(memCsN == 1'b1, "R1 cs in reset", memCsN, 1);
    chk(memMode == 1'b1 && memOeN == 1'b1 && memWeN == 1'b1, "R1 mode/oe/we in reset",
        {memMode, memOeN, memWeN}, 7);
    chk(ready == 1'b0, "R1 ready in reset", ready, 0);
    rstN = 1'b1;
    runInit("after reset", 1'b0);

    // R4 / R5 pass-through table in the ready state
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      accReq = VEC[i][11];
      setAcc(VEC[i][10:6]);
      #1;
      chk({accStall, memCsN, memOeN, memWeN, memLbN, memUbN} == VEC[i][5:0],
          "R4 R5 pass-through", {accStall, memCsN, memOeN, memWeN, memLbN, memUbN}, VEC[i][5:0]);
      chk(memMode == 1'b1, "R4 mode high when ready", memMode, 1);
    end

    // R9 wake in ready has no effect
    pulseReq(4);
    chk(ready == 1'b1, "R9 wake ignored in ready", ready, 1);

    // R6 light standby, access pins low must not leak
    setAcc(5'b00000);
    accReq = 1'b1;
    pulseReq(1);
    chk(ready == 1'b0 && memCsN == 1'b1 && memOeN == 1'b1, "R6 light standby pins",
        {ready, memCsN, memOeN}, 3);
    chk(memMode == 1'b1, "R6 mode kept high", memMode, 1);
    chk(accStall == 1'b1, "R5 stall in standby", accStall, 1);
    pulseReq(4);
    chk(ready == 1'b1, "R6 fast wake", ready, 1);

    // R7 light standby then deep standby
    pulseReq(1);
    pulseReq(2);
    chk(memMode == 1'b0 && memCsN == 1'b1, "R7 deep from light", {memMode, memCsN}, 1);
    chk(ready == 1'b0, "R7 not ready in deep", ready, 0);

    // R8 wake from deep with requests injected during init (R9)
    pulseReq(4);
    chk(memMode == 1'b1 && ready == 1'b0, "R8 mode restored on wake", {memMode, ready}, 2);
    runInit("wake with injected requests", 1'b1);

    // R7 both requests together, deep wins
    setAcc(5'b00000);
    pulseReq(3);
    chk(memMode == 1'b0, "R7 deep priority", memMode, 0);
    chk(memCsN == 1'b1, "R7 cs high in deep", memCsN, 1);
    pulseReq(4);
    runInit("wake after priority", 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule